// File: doc/BRIEF.md
# Daisy-Chained Sample Readout Sequencer

This block sequences the serial readout of one switched-capacitor sampling array that shares its analog output line with further arrays wired in a chain. A read-in token accepted while idle is loaded into a shift register with one stage per storage cell: first the waveform cells, then a few identification cells. The register advances once per phase cycle. Each phase cycle has four slots: amplifier reset, dead, cell connect, dead. The two phase strobes therefore never overlap. The register contents form a one-hot select bus for the cells.

When the token leaves the last stage, the block drops its output enable and releases the shared line. In the same clock it issues a one-clock read-out-done pulse, which feeds the read-in of the next chip. A discharge control keeps the cells shorted between events. The discharge opens on a rising gate and closes again on the done pulse. With zero suppression enabled, a chip that saw no over-threshold signal while the gate was high passes the token straight on and reads nothing out.

Top module: `sample_readout_seq`

## Requirements
- R1: After reset, sel_o is all zero, out_en_o, ph_rst_o, ph_rd_o and rbo_o are low, and dchg_o is high (cells shorted).
- R2: A read-in pulse that is accepted for readout raises out_en_o on the next clock. From that clock on, sel_o bit 0 is set and the slots run in the order reset (ph_rst_o high), dead, connect (ph_rd_o high), dead, each lasting PH_W clocks.
- R3: The token advances one bit position per phase cycle, through N_SAMPLE+N_ID stages. While out_en_o is high, sel_o has exactly one bit set. While it is low, sel_o is zero.
- R4: ph_rst_o and ph_rd_o are never high together, and a clock with both low separates every fall of one from any rise of the other.
- R5: After the final stage's phase cycle, out_en_o falls and rbo_o is high for exactly one clock, in the same clock.
- R6: dchg_o goes low on the clock after a rising gate_i and goes high in the clock where rbo_o pulses.
- R7: When zs_en_i is high and no hit is recorded, an arriving read-in pulse produces rbo_o on the next clock, with out_en_o, both phases and sel_o staying low.
- R8: A hit is recorded only when over_thr_i is high while gate_i is high. It is cleared by each rising gate_i. With zs_en_i low, every token is read out.
- R9: A read-in pulse that arrives while out_en_o is high is ignored: the sequence runs on unchanged and yields a single rbo_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rbi_i | input | 1 | Read-in token pulse from previous chip |
| gate_i | input | 1 | Acquisition gate; rising edge starts sampling |
| over_thr_i | input | 1 | Signal-above-threshold comparator result |
| zs_en_i | input | 1 | Zero-suppression enable |
| sel_o | output | N_SAMPLE+N_ID | One-hot cell select |
| ph_rst_o | output | 1 | Phase 1: output amplifier reset |
| ph_rd_o | output | 1 | Phase 2: selected cell connected to output |
| out_en_o | output | 1 | Output amplifier drives the shared line |
| rbo_o | output | 1 | Read-out-done token to next chip |
| dchg_o | output | 1 | Cell discharge switches closed |

## Verification
The bench builds the block with N_SAMPLE=8, N_ID=4 and PH_W=2. The whole 12-stage pass then takes 96 clocks, so the token can be followed clock by clock through every stage, including the hand-off out of the last one. A slot length of two clocks shows that the dead slots really separate the phases and that the slots last PH_W clocks, not one. With the short chain, all combinations of suppression enable, threshold hit and gate coincidence fit into a few hundred clocks.

// File: rtl/ro_pkg.sv
package ro_pkg;
  typedef enum logic [1:0] {
    SL_RST  = 2'd0,
    SL_GAP1 = 2'd1,
    SL_CONN = 2'd2,
    SL_GAP2 = 2'd3
  } slot_e;
endpackage

// File: rtl/ro_phase_gen.sv
module ro_phase_gen
  import ro_pkg::*;
#(
  parameter int PH_W = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  run_i,
  output slot_e slot_o,
  output logic  wrap_o
);
  localparam int CW = (PH_W > 1) ? $clog2(PH_W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PH_W - 1);

  logic [CW-1:0] cnt_q;
  slot_e         slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SL_RST;
      cnt_q  <= '0;
    end else if (start_i) begin
      slot_q <= SL_RST;
      cnt_q  <= '0;
    end else if (run_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        slot_q <= slot_e'(slot_q + 2'd1);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign slot_o = slot_q;
  assign wrap_o = run_i && (slot_q == SL_GAP2) && (cnt_q == CNT_LAST);
endmodule

// File: rtl/ro_token_sr.sv
module ro_token_sr #(
  parameter int STAGES = 132
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  output logic [STAGES-1:0] sel_o,
  output logic              last_o
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_head
      assign d = load_i ? 1'b1 : (shift_i ? 1'b0 : q[0]);
    end else begin : g_body
      assign d = load_i ? 1'b0 : (shift_i ? q[i-1] : q[i]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else         q[i] <= d;
    end
  end

  assign sel_o  = q;
  assign last_o = q[STAGES-1];
endmodule

// File: rtl/ro_acq_flags.sv
module ro_acq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic over_thr_i,
  input  logic close_i,
  output logic hit_o,
  output logic dchg_o
);
  logic gate_q, hit_q, dchg_q;
  logic gate_rise;

  assign gate_rise = gate_i && !gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      hit_q  <= 1'b0;
      dchg_q <= 1'b1;
    end else begin
      gate_q <= gate_i;
      // new gate restarts coincidence window
      if (gate_rise)   hit_q <= over_thr_i;
      else if (gate_i) hit_q <= hit_q | over_thr_i;
      // gate opening wins over a same-cycle close
      if (gate_rise)    dchg_q <= 1'b0;
      else if (close_i) dchg_q <= 1'b1;
    end
  end

  assign hit_o  = hit_q;
  assign dchg_o = dchg_q;
endmodule

// File: rtl/sample_readout_seq.sv
module sample_readout_seq
  import ro_pkg::*;
#(
  parameter int N_SAMPLE = 128,
  parameter int N_ID     = 4,
  parameter int PH_W     = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rbi_i,
  input  logic                       gate_i,
  input  logic                       over_thr_i,
  input  logic                       zs_en_i,
  output logic [N_SAMPLE+N_ID-1:0]   sel_o,
  output logic                       ph_rst_o,
  output logic                       ph_rd_o,
  output logic                       out_en_o,
  output logic                       rbo_o,
  output logic                       dchg_o
);
  localparam int STAGES = N_SAMPLE + N_ID;

  logic  busy_q, rbo_q;
  logic  accept, suppress, start, skip, done, rbo_d;
  logic  wrap, last, hit;
  slot_e slot;

  assign accept   = rbi_i && !busy_q;
  assign suppress = zs_en_i && !hit;
  assign start    = accept && !suppress;
  assign skip     = accept && suppress;
  assign done     = wrap && last;
  assign rbo_d    = skip || done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rbo_q  <= 1'b0;
    end else begin
      rbo_q <= rbo_d;
      if (start)     busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
    end
  end

  ro_phase_gen #(.PH_W(PH_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (busy_q),
    .slot_o  (slot),
    .wrap_o  (wrap)
  );

  ro_token_sr #(.STAGES(STAGES)) u_token (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .shift_i (wrap),
    .sel_o   (sel_o),
    .last_o  (last)
  );

  ro_acq_flags u_acq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_i     (gate_i),
    .over_thr_i (over_thr_i),
    .close_i    (rbo_d),
    .hit_o      (hit),
    .dchg_o     (dchg_o)
  );

  assign ph_rst_o = busy_q && (slot == SL_RST);
  assign ph_rd_o  = busy_q && (slot == SL_CONN);
  assign out_en_o = busy_q;
  assign rbo_o    = rbo_q;
endmodule

// File: rtl/sample_readout_seq_chk.sv
module sample_readout_seq_chk #(
  parameter int STAGES = 132
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAGES-1:0] sel_o,
  input logic              ph_rst_o,
  input logic              ph_rd_o,
  input logic              out_en_o,
  input logic              rbo_o,
  input logic              dchg_o
);
  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph_rst_o && ph_rd_o));
  a_r4_gap_after_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_rst_o) |-> !ph_rd_o);
  a_r4_gap_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_rd_o) |-> !ph_rst_o);
  a_r3_onehot_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> ($countones(sel_o) == 1));
  a_r3_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_o |-> (sel_o == '0));
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> (sel_o[0] && ph_rst_o));
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbo_o |=> !rbo_o);
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbo_o |-> !out_en_o);
  a_r6_close_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbo_o |-> dchg_o);
endmodule

bind sample_readout_seq sample_readout_seq_chk #(.STAGES(STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_o    (sel_o),
  .ph_rst_o (ph_rst_o),
  .ph_rd_o  (ph_rd_o),
  .out_en_o (out_en_o),
  .rbo_o    (rbo_o),
  .dchg_o   (dchg_o)
);

// File: tb/sample_readout_seq_tb.sv
module sample_readout_seq_tb;
  localparam int N_SAMPLE = 8;
  localparam int N_ID     = 4;
  localparam int PH_W     = 2;
  localparam int STAGES   = N_SAMPLE + N_ID;
  localparam int T_READ   = STAGES * 4 * PH_W;
  // {zs_en, over_thr, coincident with gate, expect readout}
  localparam logic [3:0] VEC [0:4] = '{4'b0011, 4'b0111, 4'b1111, 4'b1010, 4'b1100};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rbi = 1'b0, gate = 1'b0, over_thr = 1'b0, zs_en = 1'b0;
  logic [STAGES-1:0] sel;
  logic ph_rst, ph_rd, out_en, rbo, dchg;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sample_readout_seq #(.N_SAMPLE(N_SAMPLE), .N_ID(N_ID), .PH_W(PH_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rbi_i(rbi), .gate_i(gate),
    .over_thr_i(over_thr), .zs_en_i(zs_en), .sel_o(sel),
    .ph_rst_o(ph_rst), .ph_rd_o(ph_rd), .out_en_o(out_en),
    .rbo_o(rbo), .dchg_o(dchg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  task automatic run_case(input logic [3:0] v, input bit inject);
    bit zs, thr, coinc, rd;
    int bad;
    {zs, thr, coinc, rd} = v;
    zs_en = zs;
    @(negedge clk);
    gate = 1'b1; over_thr = thr & coinc;
    @(negedge clk);
    gate = 1'b0; over_thr = thr & ~coinc;
    chk("R6 discharge open after gate", dchg, 1'b0);
    @(negedge clk);
    over_thr = 1'b0;
    rbi = 1'b1;
    @(negedge clk);
    rbi = 1'b0;
    if (rd) begin
      bad = 0;
      for (int k = 0; k < T_READ; k++) begin
        int stage = k / (4 * PH_W);
        int s = (k / PH_W) % 4;
        logic [STAGES-1:0] es = STAGES'(1) << stage;
        if (k == 0) chk("R2 R8 readout started", {out_en, ph_rst, sel[0]}, 3'b111);
        if (sel !== es || ph_rst !== (s == 0) || ph_rd !== (s == 2) || out_en !== 1'b1 ||
            rbo !== 1'b0) begin
          if (bad == 0) $display("FAIL R3 R4 at k=%0d actual=%0h expected=%0h", k, sel, es);
          bad++;
        end
        if (inject && k == 10) rbi = 1'b1;
        if (inject && k == 11) rbi = 1'b0;
        @(negedge clk);
      end
      checks++; if (bad != 0) errors++;
      chk("R5 release and done pulse", {out_en, rbo, sel != '0}, 3'b010);
      chk("R6 discharge closed on done", dchg, 1'b1);
      @(negedge clk);
      chk("R5 done is one clock", rbo, 1'b0);
      if (inject) begin
        repeat (20) begin
          @(negedge clk);
          if (out_en || rbo) bad++;
        end
        chk("R9 token during readout ignored", bad, 0);
      end
    end else begin
      chk("R7 skip forwards token", {rbo, out_en, ph_rst, ph_rd}, 4'b1000);
      chk("R7 no cell select on skip", sel, '0);
      chk("R6 discharge closed on skip", dchg, 1'b1);
      @(negedge clk);
      chk("R7 done is one clock", {rbo, out_en}, 2'b00);
    end
  endtask

  initial begin
    #20;
    chk("R1 reset select", sel, '0);
    chk("R1 reset controls", {ph_rst, ph_rd, out_en, rbo, dchg}, 5'b00001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {ph_rst, ph_rd, out_en, rbo, dchg}, 5'b00001);
    for (int i = 0; i < 5; i++) run_case(VEC[i], i == 1);
    // R8: hit from a previous gate cleared by a new gate without coincidence
    run_case(4'b1111, 1'b0);
    run_case(4'b1010, 1'b0);
    report();
  end
endmodule